// File: doc/BRIEF.md
# Banked Clock/Calendar Register File Host Port

This block is the host-facing side of a real-time-clock register file. Software reaches two 128-byte banks through four byte-wide I/O ports. A pointer port and a data port serve the clock bank, and a second pair serves the general-purpose bank. A write to a pointer port selects a byte. Later data-port reads and writes go to that byte.

In the clock bank, four locations near the bottom are not RAM. Offsets 0x0A and 0x0B are writable control flops, and their values drive the timekeeping core. Offset 0x0C is an event-flag register that collects pulses from the core and clears when it is read. Offset 0x0D mirrors a status byte from the core. Every other offset in both banks is a plain byte of storage.

A clock-enable input gates the clock bank only. While it is low, data reads from the clock bank return 0xFF and data writes to it are dropped. The general-purpose bank keeps working.

Top module: `rtc_bank_regs`

## Requirements
- R1: After reset, both pointers are 0, the control flops at offsets 0x0A and 0x0B are 0, the flag register is 0 and `io_rdata` is 0.
- R2: Port select 0 is the clock-bank pointer and port select 2 is the general-bank pointer. A write to either keeps the low 7 bits of `io_wdata`. A read of either returns the pointer with bit 7 forced to 0.
- R3: With `rtc_en` high, port select 1 reads and writes the clock-bank byte at the pointer for offsets 0x00–0x09 and 0x0E–0x7F. Read data appears on `io_rdata` one clock after the read strobe and holds until the next read.
- R4: A clock-bank write at offset 0x0A or 0x0B loads a control flop. The flop drives `ctrl_a` or `ctrl_b` from the next clock, and a read of the same offset returns it.
- R5: Offset 0x0C reads the flag register. Each bit is set by a one-cycle high on the matching bit of `flag_set` and stays set. A clock-bank read of 0x0C returns the value held before the read and clears it to 0. A flag that pulses in the same cycle as that read is kept. Writes to 0x0C are ignored.
- R6: Offset 0x0D reads return the live `stat_d` input, and writes to 0x0D are ignored.
- R7: While `rtc_en` is low, clock-bank data reads return 0xFF. Clock-bank data writes change neither RAM nor the control flops, and reads do not clear the flag register. The stored contents are unchanged when the enable returns.
- R8: Port select 3 reads and writes a separate 128-byte bank at the general pointer, at every offset including 0x0A–0x0D. This bank works whether `rtc_en` is high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rtc_en | input | 1 | Enables host data access to the clock bank |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access (ignored when io_wr is high) |
| io_addr | input | 2 | Port select: 0 clock pointer, 1 clock data, 2 general pointer, 3 general data |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| flag_set | input | 8 | Event pulses from the core that set flag-register bits |
| stat_d | input | 8 | Status byte returned at offset 0x0D |
| ctrl_a | output | 8 | Control flop at offset 0x0A |
| ctrl_b | output | 8 | Control flop at offset 0x0B |

## Verification
Every result of this block is due exactly one clock after its stimulus. Read data lands on `io_rdata` at the edge that samples the read strobe. Control-flop outputs and flag bits change at the edge that samples the write or the pulse. The bench applies each strobe at a falling edge and removes it at the next falling edge, then samples the outputs there, half a period after the edge that produced them. Checks of ignored writes and flag retention read the state back through the normal ports in a following access.

// File: rtl/rtc_bank_regs.sv
module rtc_bank_regs #(
  parameter int OFS_W = 7,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rtc_en,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [1:0]    io_addr,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  input  logic [DW-1:0] flag_set,
  input  logic [DW-1:0] stat_d,
  output logic [DW-1:0] ctrl_a,
  output logic [DW-1:0] ctrl_b
);
  localparam int DEPTH = 1 << OFS_W;
  localparam logic [OFS_W-1:0] OFS_A = 'd10;
  localparam logic [OFS_W-1:0] OFS_B = 'd11;
  localparam logic [OFS_W-1:0] OFS_C = 'd12;
  localparam logic [OFS_W-1:0] OFS_D = 'd13;

  logic [OFS_W-1:0] std_idx, ext_idx;
  logic [DW-1:0]    reg_c, rd_next;
  logic [DW-1:0]    std_mem [DEPTH];
  logic [DW-1:0]    ext_mem [DEPTH];

  wire rd_go   = io_rd && !io_wr;
  wire s_wr    = io_wr && (io_addr == 2'd1) && rtc_en;
  wire s_rd    = rd_go && (io_addr == 2'd1) && rtc_en;
  wire e_wr    = io_wr && (io_addr == 2'd3);
  wire is_reg  = (std_idx >= OFS_A) && (std_idx <= OFS_D);
  wire c_clr   = s_rd && (std_idx == OFS_C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      std_idx <= '0;
      ext_idx <= '0;
    end else if (io_wr) begin
      if (io_addr == 2'd0) std_idx <= io_wdata[OFS_W-1:0];
      if (io_addr == 2'd2) ext_idx <= io_wdata[OFS_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_a <= '0;
      ctrl_b <= '0;
    end else if (s_wr) begin
      if (std_idx == OFS_A) ctrl_a <= io_wdata;
      if (std_idx == OFS_B) ctrl_b <= io_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_c <= '0;
    else        reg_c <= (c_clr ? '0 : reg_c) | flag_set;
  end

  always_ff @(posedge clk) begin
    if (s_wr && !is_reg) std_mem[std_idx] <= io_wdata;
    if (e_wr)            ext_mem[ext_idx] <= io_wdata;
  end

  always_comb begin
    case (io_addr)
      2'd0: rd_next = {{(DW-OFS_W){1'b0}}, std_idx};
      2'd2: rd_next = {{(DW-OFS_W){1'b0}}, ext_idx};
      2'd3: rd_next = ext_mem[ext_idx];
      default: begin
        if (!rtc_en) rd_next = '1;
        else begin
          case (std_idx)
            OFS_A:   rd_next = ctrl_a;
            OFS_B:   rd_next = ctrl_b;
            OFS_C:   rd_next = reg_c;
            OFS_D:   rd_next = stat_d;
            default: rd_next = std_mem[std_idx];
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     io_rdata <= '0;
    else if (rd_go) io_rdata <= rd_next;
  end

  assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 2'd0) |=> std_idx == $past(io_wdata[OFS_W-1:0]));

  assert_ctrl_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rtc_en) |=> ($stable(ctrl_a) && $stable(ctrl_b)));

  assert_off_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && io_addr == 2'd1 && !rtc_en) |=> io_rdata == '1);

  assert_flag_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    c_clr |=> (io_rdata == $past(reg_c)) && (reg_c == $past(flag_set)));

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_clr) |=> ((reg_c & $past(reg_c)) == $past(reg_c)));

  assert_stat_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rd && std_idx == OFS_D) |=> io_rdata == $past(stat_d));
endmodule

// File: tb/rtc_bank_regs_bench.sv
module rtc_bank_regs_bench;
  localparam int CLK_P = 10;

  logic       clk = 0, rst_n = 0, rtc_en = 1, io_wr = 0, io_rd = 0;
  logic [1:0] io_addr = 0;
  logic [7:0] io_wdata = 0, flag_set = 0, stat_d = 0;
  logic [7:0] io_rdata, ctrl_a, ctrl_b;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  rtc_bank_regs u_rtc_bank_regs (
    .clk(clk), .rst_n(rst_n), .rtc_en(rtc_en), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .flag_set(flag_set), .stat_d(stat_d), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1;
    @(negedge clk); io_rd = 0; d = io_rdata;
  endtask

  task automatic pulse(logic [7:0] f);
    @(negedge clk); flag_set = f;
    @(negedge clk); flag_set = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 rdata", io_rdata, 8'h00);
    chk("R1 ctrl_a", ctrl_a, 8'h00);
    chk("R1 ctrl_b", ctrl_b, 8'h00);
    rd(2'd0, d); chk("R1 clock ptr", d, 8'h00);
    rd(2'd2, d); chk("R1 general ptr", d, 8'h00);
    wr(2'd0, 8'h0C); rd(2'd1, d); chk("R1 flags", d, 8'h00);
  endtask

  task automatic t_index;
    logic [7:0] d;
    wr(2'd0, 8'h85); rd(2'd0, d); chk("R2 clock ptr masked", d, 8'h05);
    wr(2'd2, 8'hFF); rd(2'd2, d); chk("R2 general ptr masked", d, 8'h7F);
  endtask

  task automatic t_ram;
    logic [7:0] d;
    foreach (d[i]) begin end
    wr(2'd0, 8'h00); wr(2'd1, 8'h11);
    wr(2'd0, 8'h09); wr(2'd1, 8'h99);
    wr(2'd0, 8'h0E); wr(2'd1, 8'hE0);
    wr(2'd0, 8'h7F); wr(2'd1, 8'h7C);
    wr(2'd0, 8'h00); rd(2'd1, d); chk("R3 ofs 00", d, 8'h11);
    wr(2'd0, 8'h09); rd(2'd1, d); chk("R3 ofs 09", d, 8'h99);
    wr(2'd0, 8'h0E); rd(2'd1, d); chk("R3 ofs 0E", d, 8'hE0);
    wr(2'd0, 8'h7F); rd(2'd1, d); chk("R3 ofs 7F", d, 8'h7C);
    repeat (3) @(negedge clk);
    chk("R3 rdata holds", io_rdata, 8'h7C);
  endtask

  task automatic t_ctrl;
    logic [7:0] d;
    wr(2'd0, 8'h0A); wr(2'd1, 8'h26);
    chk("R4 ctrl_a out", ctrl_a, 8'h26);
    wr(2'd0, 8'h0B); wr(2'd1, 8'h82);
    chk("R4 ctrl_b out", ctrl_b, 8'h82);
    rd(2'd1, d); chk("R4 read B", d, 8'h82);
    wr(2'd0, 8'h0A); rd(2'd1, d); chk("R4 read A", d, 8'h26);
  endtask

  task automatic t_flags;
    logic [7:0] d;
    pulse(8'h20); pulse(8'h40);
    wr(2'd0, 8'h0C); rd(2'd1, d); chk("R5 accumulated", d, 8'h60);
    rd(2'd1, d); chk("R5 cleared by read", d, 8'h00);
    wr(2'd1, 8'hFF); rd(2'd1, d); chk("R5 write ignored", d, 8'h00);
    @(negedge clk); io_addr = 2'd1; io_rd = 1; flag_set = 8'h10;
    @(negedge clk); io_rd = 0; flag_set = 0; d = io_rdata;
    chk("R5 read returns old", d, 8'h00);
    rd(2'd1, d); chk("R5 same-cycle pulse kept", d, 8'h10);
  endtask

  task automatic t_stat;
    logic [7:0] d;
    stat_d = 8'h80;
    wr(2'd0, 8'h0D); rd(2'd1, d); chk("R6 status", d, 8'h80);
    wr(2'd1, 8'h00); rd(2'd1, d); chk("R6 write ignored", d, 8'h80);
    stat_d = 8'h3A; rd(2'd1, d); chk("R6 live", d, 8'h3A);
  endtask

  task automatic t_disable;
    logic [7:0] d;
    wr(2'd0, 8'h0E);
    rtc_en = 0;
    rd(2'd1, d); chk("R7 read FF", d, 8'hFF);
    wr(2'd1, 8'h55);
    wr(2'd0, 8'h0A); wr(2'd1, 8'h11);
    chk("R7 ctrl_a held", ctrl_a, 8'h26);
    pulse(8'h08);
    wr(2'd0, 8'h0C); rd(2'd1, d); chk("R7 flag read FF", d, 8'hFF);
    wr(2'd2, 8'h40); wr(2'd3, 8'h5A); rd(2'd3, d); chk("R8 general while off", d, 8'h5A);
    rtc_en = 1;
    rd(2'd1, d); chk("R7 flag not cleared", d, 8'h08);
    wr(2'd0, 8'h0E); rd(2'd1, d); chk("R7 RAM unchanged", d, 8'hE0);
  endtask

  task automatic t_ext;
    logic [7:0] d;
    wr(2'd2, 8'h0E); wr(2'd3, 8'hA5);
    rd(2'd3, d); chk("R8 general byte", d, 8'hA5);
    wr(2'd0, 8'h0E); rd(2'd1, d); chk("R8 banks separate", d, 8'hE0);
    wr(2'd2, 8'h0C); wr(2'd3, 8'h3C);
    rd(2'd3, d); chk("R8 ofs 0C plain", d, 8'h3C);
    wr(2'd2, 8'h0E); rd(2'd3, d); chk("R8 first byte kept", d, 8'hA5);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_index;
    t_ram;
    t_ctrl;
    t_flags;
    t_stat;
    t_disable;
    t_ext;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule